// File: doc/BRIEF.md
# External Bus Hand-Over Arbiter

This block decides who owns the chip's external memory bus: the on-chip bus controller or an outside bus master. The outside master asks for the bus by pulling an active-low request line. The arbiter synchronises that line and waits for the current external cycle to finish. It then answers with an active-low acknowledge and turns off the output enables of the address, data and control pin groups, so those pins float. While the bus is given away, internal masters keep working on internal space. Only two things wait: their accesses to external space, and any write that changes the clock-frequency setting.

While the bus is given away, the arbiter can also pull an active-low give-back line. This asks the outside master to return the bus, and it does so when external work is waiting inside the chip: an external-space access, a deep standby entry, or a clock-frequency write. When the request line goes high again, the arbiter drops the acknowledge first. It turns the pin drivers back on one cycle later. On the cycle after that, the waiting access may start and any held clock setting takes effect. Control-register bits arrive as plain inputs.

Top module: `ext_bus_release`

## Requirements
- R1: When `rel_en` or `pin_in_en` is 0, a low `ext_req_n` is ignored: `ack_n` stays 1 and all output enables stay 1.
- R2: With both enables at 1 and `cyc_idle` at 1, `ack_n` goes low on the third rising clock edge after `ext_req_n` is first low (two synchroniser stages plus one state register). It stays low while the synchronised request stays low.
- R3: Whenever `ack_n` is 0, `addr_oe`, `data_oe` and `ctrl_oe` are all 0.
- R4: `busy` is 1 whenever the bus is released or recovering, and also in the cycle in which a release is being taken.
- R5: `int_ext_go` is 0 whenever the bus is not owned by the chip, even when `int_ext_req` is 1. It follows `int_ext_req` once the output enables are back at 1.
- R6: A `clk_wr` strobe while the bus is not owned does not change `clk_setting`. The latest value written is applied on the second rising edge after the output enables return to 1.
- R7: `reqback_n` is 0 only while the bus is released with `ack_n` at 0, `reqback_en` at 1, and at least one of these true: `int_ext_req`, `stby_req`, `clk_wr`, or a held clock write. Otherwise it is 1.
- R8: If the synchronised release request and `int_ext_req` are both present in a cycle where the bus could be taken, the release wins: `int_ext_go` is 0 and `busy` is 1 in that cycle.
- R9: A release is taken only in a cycle with `cyc_idle` at 1, so an external cycle that is under way is never cut short.
- R10: After `ext_req_n` returns high, `ack_n` returns to 1 on the third rising edge after the change. The output enables return to 1 one edge later.
- R11: A `clk_wr` strobe while the bus is owned loads `clk_wr_val` into `clk_setting` on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rel_en | input | 1 | Release-enable control bit |
| pin_in_en | input | 1 | Input-enable configuration of the request pin |
| reqback_en | input | 1 | Enables the give-back request output |
| ext_req_n | input | 1 | Asynchronous active-low bus request from the outside master |
| cyc_idle | input | 1 | High when no external bus cycle is under way |
| int_ext_req | input | 1 | Internal master wants an external-space access |
| stby_req | input | 1 | Deep standby or all-clocks-stopped entry is waiting |
| clk_wr | input | 1 | Strobe for a granted clock-frequency write |
| clk_wr_val | input | CLK_W | New clock-frequency setting |
| ack_n | output | 1 | Active-low acknowledge to the outside master |
| reqback_n | output | 1 | Active-low request for the bus to be given back |
| addr_oe | output | 1 | Output enable of the address pins |
| data_oe | output | 1 | Output enable of the data pins |
| ctrl_oe | output | 1 | Output enable of the bus-control pins |
| busy | output | 1 | Tells the cycle engine not to start new external cycles |
| int_ext_go | output | 1 | Permission to start the internal external-space access |
| clk_setting | output | CLK_W | Clock-frequency setting currently in effect |

## Verification
The hardest case to reach is a clock write that lands while the bus is released and is then overwritten before the bus comes back. Only the last value may appear, and it must appear only after the drivers are back on. A directed sequence holds the request low, pulses two writes during the release, and counts edges on the way out. Random stimulus keeps the request line low for long stretches and mixes idle and busy cycles with writes and standby requests. This produces collisions between a release and an internal request, and releases that overlap a running cycle.

// File: rtl/ebr_pkg.sv
// Package: shared state encoding for the external bus hand-over arbiter.
// Assumes: a two-bit encoding is enough for three ownership states.
package ebr_pkg;
    typedef enum logic [1:0] {
        ST_OWN = 2'd0,   // chip drives the external bus
        ST_REL = 2'd1,   // bus given to the outside master
        ST_REC = 2'd2    // acknowledge dropped, drivers still off
    } rel_state_e;
endpackage

// File: rtl/ebr_sync.sv
// Module: multi-stage synchroniser for an active-low asynchronous input.
// Assumes: the input idles high; the flops reset to the idle level.
module ebr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= async_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_n};
            end
        end
    endgenerate

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ebr_fsm.sv
// Module: ownership state machine for the external bus.
// Takes the bus away from the chip at a cycle boundary and hands it back
// through a one-cycle recovery step. Assumes req_on is already synchronised.
module ebr_fsm
    import ebr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_on,
    input  logic       cyc_idle,
    input  logic       int_ext_req,
    output rel_state_e st_q,
    output logic       busy,
    output logic       int_ext_go
);
    rel_state_e st_d;
    logic       take;

    // Decide whether a release is taken in this cycle.
    assign take = (st_q == ST_OWN) && req_on && cyc_idle;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_OWN:  if (take)    st_d = ST_REL;
            ST_REL:  if (!req_on) st_d = ST_REC;
            ST_REC:               st_d = ST_OWN;
            default:              st_d = ST_OWN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OWN;
        else        st_q <= st_d;
    end

    // Gate the cycle engine and the internal external-space access.
    assign busy       = (st_q != ST_OWN) || take;
    assign int_ext_go = int_ext_req && !busy;

    AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && int_ext_req) |-> !int_ext_go); // R8
    AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OWN && !cyc_idle) |=> (st_q == ST_OWN)); // R9
    AST_RECOVER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REC) |=> (st_q == ST_OWN)); // R10
endmodule

// File: rtl/ebr_clkhold.sv
// Module: holds a clock-frequency write while the bus is not owned and
// applies it once ownership returns. The latest write while held wins.
module ebr_clkhold #(
    parameter int          CLK_W   = 4,
    parameter logic [CLK_W-1:0] CLK_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             owned,
    input  logic             clk_wr,
    input  logic [CLK_W-1:0] clk_wr_val,
    output logic [CLK_W-1:0] clk_setting,
    output logic             pend
);
    logic [CLK_W-1:0] hold_q;

    // Commit at once when owned, otherwise park the value until ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_setting <= CLK_RST;
            hold_q      <= CLK_RST;
            pend        <= 1'b0;
        end else if (owned) begin
            if (clk_wr) begin
                clk_setting <= clk_wr_val;
                pend        <= 1'b0;
            end else if (pend) begin
                clk_setting <= hold_q;
                pend        <= 1'b0;
            end
        end else if (clk_wr) begin
            hold_q <= clk_wr_val;
            pend   <= 1'b1;
        end
    end

    AST_NO_COMMIT_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        !owned |=> $stable(clk_setting)); // R6
endmodule

// File: rtl/ext_bus_release.sv
// Module: external bus hand-over arbiter (top).
// Synchronises the outside request, runs the ownership machine, decodes the
// pin-group enables and the give-back request, and defers clock writes.
// Assumes cyc_idle comes from the cycle engine in the same clock domain.
module ext_bus_release
    import ebr_pkg::*;
#(
    parameter int               CLK_W       = 4,
    parameter logic [CLK_W-1:0] CLK_RST     = '0,
    parameter int               SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rel_en,
    input  logic             pin_in_en,
    input  logic             reqback_en,
    input  logic             ext_req_n,
    input  logic             cyc_idle,
    input  logic             int_ext_req,
    input  logic             stby_req,
    input  logic             clk_wr,
    input  logic [CLK_W-1:0] clk_wr_val,
    output logic             ack_n,
    output logic             reqback_n,
    output logic             addr_oe,
    output logic             data_oe,
    output logic             ctrl_oe,
    output logic             busy,
    output logic             int_ext_go,
    output logic [CLK_W-1:0] clk_setting
);
    logic       req_sync_n;
    logic       req_on;
    logic       pend;
    logic       owned;
    rel_state_e st_q;

    ebr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_n(ext_req_n), .sync_n(req_sync_n)
    );

    // Request counts only when both enable bits allow a release.
    assign req_on = !req_sync_n && rel_en && pin_in_en;

    ebr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_on(req_on), .cyc_idle(cyc_idle),
        .int_ext_req(int_ext_req), .st_q(st_q), .busy(busy),
        .int_ext_go(int_ext_go)
    );

    assign owned = (st_q == ST_OWN);

    ebr_clkhold #(.CLK_W(CLK_W), .CLK_RST(CLK_RST)) u_clk (
        .clk(clk), .rst_n(rst_n), .owned(owned), .clk_wr(clk_wr),
        .clk_wr_val(clk_wr_val), .clk_setting(clk_setting), .pend(pend)
    );

    // Pin-group enables and acknowledge decoded from the ownership state.
    assign ack_n   = (st_q != ST_REL);
    assign addr_oe = owned;
    assign data_oe = owned;
    assign ctrl_oe = owned;

    // Give-back request while released and internal external work waits.
    assign reqback_n = !((st_q == ST_REL) && reqback_en &&
                         (int_ext_req || stby_req || clk_wr || pend));

    AST_FLOAT_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> (!addr_oe && !data_oe && !ctrl_oe)); // R3
    AST_NO_GO_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        int_ext_go |-> (addr_oe && ack_n)); // R5
    AST_REQBACK_IN_REL: assert property (@(posedge clk) disable iff (!rst_n)
        !reqback_n |-> (!ack_n && reqback_en)); // R7
    AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rel_en || !pin_in_en) && ack_n) |=> ack_n); // R1
    AST_BUSY_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_oe |-> busy); // R4
endmodule

// File: tb/ext_bus_release_tb.sv
`timescale 1ns/100ps
// Bench: directed corner cases followed by seeded random stimulus, all
// compared against a requirement-level model kept in bench functions.
module ext_bus_release_tb_top;
    localparam int CLK_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rel_en = 1'b1, pin_in_en = 1'b1, reqback_en = 1'b1;
    logic ext_req_n = 1'b1, cyc_idle = 1'b1, int_ext_req = 1'b0;
    logic stby_req = 1'b0, clk_wr = 1'b0;
    logic [CLK_W-1:0] clk_wr_val = '0;
    logic ack_n, reqback_n, addr_oe, data_oe, ctrl_oe, busy, int_ext_go;
    logic [CLK_W-1:0] clk_setting;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ext_bus_release #(.CLK_W(CLK_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rel_en(rel_en), .pin_in_en(pin_in_en),
        .reqback_en(reqback_en), .ext_req_n(ext_req_n), .cyc_idle(cyc_idle),
        .int_ext_req(int_ext_req), .stby_req(stby_req), .clk_wr(clk_wr),
        .clk_wr_val(clk_wr_val), .ack_n(ack_n), .reqback_n(reqback_n),
        .addr_oe(addr_oe), .data_oe(data_oe), .ctrl_oe(ctrl_oe), .busy(busy),
        .int_ext_go(int_ext_go), .clk_setting(clk_setting)
    );

    // Requirement model: 0 owned, 1 released, 2 recovering.
    logic m_s1, m_s2, m_pend;
    int   m_st;
    logic [CLK_W-1:0] m_clk, m_hold;

    function automatic logic m_req();
        return !m_s2 && rel_en && pin_in_en;
    endfunction
    function automatic logic m_take();
        return (m_st == 0) && m_req() && cyc_idle;
    endfunction
    function automatic logic m_busy();
        return (m_st != 0) || m_take();
    endfunction
    function automatic logic m_reqback_n();
        return !((m_st == 1) && reqback_en &&
                 (int_ext_req || stby_req || clk_wr || m_pend));
    endfunction

    // Advance the model on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_st <= 0;
            m_clk <= '0; m_hold <= '0; m_pend <= 1'b0;
        end else begin
            m_s1 <= ext_req_n;
            m_s2 <= m_s1;
            case (m_st)
                0: if (m_take()) m_st <= 1;
                1: if (!m_req()) m_st <= 2;
                default: m_st <= 0;
            endcase
            if (m_st == 0) begin
                if (clk_wr) begin m_clk <= clk_wr_val; m_pend <= 1'b0; end
                else if (m_pend) begin m_clk <= m_hold; m_pend <= 1'b0; end
            end else if (clk_wr) begin
                m_hold <= clk_wr_val; m_pend <= 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model.
    task automatic cmp_all();
        chk("R2 ack_n", ack_n, (m_st == 1) ? 0 : 1);
        chk("R3 addr_oe", addr_oe, (m_st == 0) ? 1 : 0);
        chk("R3 data_oe", data_oe, (m_st == 0) ? 1 : 0);
        chk("R3 ctrl_oe", ctrl_oe, (m_st == 0) ? 1 : 0);
        chk("R4 busy", busy, m_busy());
        chk("R5 int_ext_go", int_ext_go, int_ext_req && !m_busy());
        chk("R7 reqback_n", reqback_n, m_reqback_n());
        chk("R6 clk_setting", clk_setting, m_clk);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        // Reset state.
        chk("R2 reset ack_n", ack_n, 1);
        chk("R7 reset reqback_n", reqback_n, 1);
        chk("R11 reset clk", clk_setting, 0);

        // R11: write while owned commits on next edge.
        clk_wr = 1; clk_wr_val = 4'd3; cyc(); clk_wr = 0;
        chk("R11 owned commit", clk_setting, 3);

        // R1: enable off, request ignored.
        rel_en = 0; ext_req_n = 0;
        repeat (6) cyc();
        chk("R1 ack held", ack_n, 1);
        chk("R1 oe held", addr_oe, 1);
        ext_req_n = 1; rel_en = 1;
        repeat (3) cyc();

        // R2/R5/R6/R7/R10 directed release and return.
        int_ext_req = 1; ext_req_n = 0; n = 0;
        while (ack_n && n < 10) begin cyc(); n++; end
        chk("R2 latency", n, 3);
        chk("R5 go held", int_ext_go, 0);
        chk("R7 reqback low", reqback_n, 0);
        clk_wr = 1; clk_wr_val = 4'd5; cyc();
        clk_wr_val = 4'd9; cyc(); clk_wr = 0;
        chk("R6 deferred", clk_setting, 3);
        ext_req_n = 1;
        cyc(); chk("R10 ack still low", ack_n, 0);
        cyc(); cyc(); chk("R10 ack high", ack_n, 1);
        chk("R10 oe still off", addr_oe, 0);
        chk("R7 reqback back", reqback_n, 1);
        cyc(); chk("R10 oe on", addr_oe, 1);
        chk("R5 go resumes", int_ext_go, 1);
        chk("R6 not yet", clk_setting, 3);
        cyc(); chk("R6 latest applied", clk_setting, 9);

        // R8: release beats internal request in the same cycle.
        ext_req_n = 0;
        cyc(); chk("R8 go before", int_ext_go, 1);
        cyc(); chk("R8 go blocked", int_ext_go, 0);
        chk("R8 busy", busy, 1);
        ext_req_n = 1; int_ext_req = 0;
        repeat (5) cyc();

        // R9: no release while a cycle is running.
        cyc_idle = 0; ext_req_n = 0;
        repeat (5) cyc();
        chk("R9 wait for idle", ack_n, 1);
        cyc_idle = 1; cyc();
        chk("R9 taken at idle", ack_n, 0);
        ext_req_n = 1;
        repeat (5) cyc();

        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) ext_req_n = ~ext_req_n;
            if ($urandom_range(0, 49) == 0) rel_en = ~rel_en;
            if ($urandom_range(0, 49) == 0) pin_in_en = ~pin_in_en;
            if ($urandom_range(0, 29) == 0) reqback_en = ~reqback_en;
            if (!rel_en && $urandom_range(0, 3) == 0) rel_en = 1;
            if (!pin_in_en && $urandom_range(0, 3) == 0) pin_in_en = 1;
            cyc_idle    = ($urandom_range(0, 4) != 0);
            int_ext_req = ($urandom_range(0, 2) == 0);
            stby_req    = ($urandom_range(0, 9) == 0);
            clk_wr      = ($urandom_range(0, 7) == 0);
            clk_wr_val  = CLK_W'($urandom);
            cyc();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule